// File: doc/BRIEF.md
# Status Byte and Service Request Aggregator

This block forms the top level of an instrument's status hierarchy. It collects four summary sources into an 8-bit status byte: a locally held standard event register (latched from set-only event inputs and masked by its own enable register), the summary lines of the operation and questionable detail registers, and a flag saying the output buffer holds data. From that byte it derives two independent results: a service request, qualified by a service-request enable mask, and a single individual-status flag for parallel poll, qualified by a separate parallel-poll enable mask.

The event register, its enable mask and the two status-byte masks sit on a small register bus with a 2-bit address, a write strobe and a read strobe. Read data is a combinational function of the address; the read strobe only carries the clear-on-read side effect of the event register. The status byte itself, the service request and the individual-status flag are presented on dedicated outputs and follow their sources without extra latency.

Top module: `status_byte_agg`

## Requirements
- R1: After reset all four bus registers read 0, and with all status inputs low the status byte, the service request and the individual-status flag are 0.
- R2: Status byte bit 3 equals the questionable summary input, bit 4 the output-buffer-not-empty input and bit 7 the operation summary input, in the same cycle; bits 0 to 2 are always 0.
- R3: A high bit on the event input sets the matching event register bit at the next clock edge, and that bit stays set until the register is read.
- R4: A read strobe at address 0 returns the event register contents in that cycle and clears the register at the next edge, except for bits whose event input is high in that same cycle, which end up set.
- R5: Status byte bit 5 is 1 exactly when some event register bit and the same bit of the event enable register (address 1) are both 1.
- R6: Status byte bit 6 and the service request output are 1 exactly when some status byte bit other than bit 6 is 1 together with the matching service-request enable bit (address 2); they return to 0 as soon as no such pair remains.
- R7: Bit 6 of the service-request enable register cannot be set: it reads back 0 and never contributes to the service request.
- R8: The individual-status flag is 1 exactly when some status byte bit, bit 6 included, is 1 together with the matching parallel-poll enable bit (address 3).
- R9: Addresses 1, 2 and 3 are writable and read back what was written (bit 6 at address 2 excepted); a write at address 0 leaves the event register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clear-on-read side effect) |
| bus_addr | input | 2 | Register address: 0 event, 1 event enable, 2 service-request enable, 3 parallel-poll enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| evt_in | input | 8 | Set-only event pulses for the standard event register |
| oper_sum | input | 1 | Operation register summary |
| ques_sum | input | 1 | Questionable register summary |
| obuf_nonempty | input | 1 | Output buffer holds data |
| status_byte | output | 8 | Assembled status byte |
| srq | output | 1 | Service request |
| ist | output | 1 | Individual-status flag for parallel poll |

## Verification
Each source of the status byte is raised alone, then in combination, so a swapped or missing bit position shows as a wrong byte value. The service request is tried with an enable mask that matches the active source, one that misses it, and one that only covers bit 6, which separates correct masking from a request that ignores the mask or honours bit 6. The individual-status flag is tried with a mask on bit 6 alone, so it tells whether the service-request bit is included, and the event register is read while a new event arrives, which tells a clear that drops concurrent events from one that keeps them.

// File: rtl/stb_pkg.sv
package stb_pkg;
  localparam int STB_W       = 8;
  localparam int BIT_QUES    = 3;
  localparam int BIT_MAV     = 4;
  localparam int BIT_ESB     = 5;
  localparam int BIT_RQS     = 6;
  localparam int BIT_OPER    = 7;

  typedef enum logic [1:0] {
    ADDR_EVT  = 2'd0,
    ADDR_EVEN = 2'd1,
    ADDR_SREN = 2'd2,
    ADDR_PPEN = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/sbagg_rst_sync.sv
module sbagg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/sbagg_mask_or.sv
module sbagg_mask_or #(
  parameter int W    = 8,
  parameter int SKIP = -1
) (
  input  logic [W-1:0] vec,
  input  logic [W-1:0] mask,
  output logic         hit
);
  logic [W-1:0] keep;

  for (genvar i = 0; i < W; i++) begin : g_keep
    if (i == SKIP) begin : g_skip
      assign keep[i] = 1'b0;
    end else begin : g_use
      assign keep[i] = vec[i] & mask[i];
    end
  end

  assign hit = |keep;
endmodule

// File: rtl/sbagg_enable_reg.sv
module sbagg_enable_reg #(
  parameter int          W      = 8,
  parameter logic [W-1:0] STUCK0 = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (STUCK0[i]) begin : g_zero
      assign d[i] = 1'b0;
    end else begin : g_live
      assign d[i] = wdata[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/sbagg_event_reg.sv
module sbagg_event_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_in,
  input  logic         clr,
  input  logic         en_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] evt_q,
  output logic [W-1:0] en_q,
  output logic         summary
);
  logic [W-1:0] evt_d;

  always_comb begin
    evt_d = (clr ? '0 : evt_q) | evt_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= wdata;
  end

  sbagg_mask_or #(.W(W), .SKIP(-1)) u_sum (
    .vec (evt_q),
    .mask(en_q),
    .hit (summary)
  );

  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((evt_q & $past(evt_q)) == $past(evt_q))); // R3
  AST_EVT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (evt_q == $past(evt_in))); // R4
endmodule

// File: rtl/status_byte_agg.sv
module status_byte_agg
  import stb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] evt_in,
  input  logic              oper_sum,
  input  logic              ques_sum,
  input  logic              obuf_nonempty,
  output logic [STB_W-1:0]  status_byte,
  output logic              srq,
  output logic              ist
);
  localparam logic [STB_W-1:0] SREN_STUCK = STB_W'(1) << BIT_RQS;

  logic              rst_s_n;
  logic [DATA_W-1:0] evt_q, even_q;
  logic [STB_W-1:0]  sren_q, ppen_q;
  logic              esb, rqs;
  logic              evt_clr, even_we, sren_we, ppen_we;
  logic [STB_W-1:0]  stb_base;

  sbagg_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_s_n(rst_s_n)
  );

  always_comb begin
    evt_clr = bus_rd && (bus_addr == ADDR_EVT);
    even_we = bus_wr && (bus_addr == ADDR_EVEN);
    sren_we = bus_wr && (bus_addr == ADDR_SREN);
    ppen_we = bus_wr && (bus_addr == ADDR_PPEN);
  end

  sbagg_event_reg #(.W(DATA_W)) u_evt (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .evt_in (evt_in),
    .clr    (evt_clr),
    .en_we  (even_we),
    .wdata  (bus_wdata),
    .evt_q  (evt_q),
    .en_q   (even_q),
    .summary(esb)
  );

  sbagg_enable_reg #(.W(STB_W), .STUCK0(SREN_STUCK)) u_sren (
    .clk  (clk),
    .rst_n(rst_s_n),
    .we   (sren_we),
    .wdata(bus_wdata[STB_W-1:0]),
    .q    (sren_q)
  );

  sbagg_enable_reg #(.W(STB_W), .STUCK0('0)) u_ppen (
    .clk  (clk),
    .rst_n(rst_s_n),
    .we   (ppen_we),
    .wdata(bus_wdata[STB_W-1:0]),
    .q    (ppen_q)
  );

  always_comb begin
    stb_base           = '0;
    stb_base[BIT_QUES] = ques_sum;
    stb_base[BIT_MAV]  = obuf_nonempty;
    stb_base[BIT_ESB]  = esb;
    stb_base[BIT_OPER] = oper_sum;
  end

  sbagg_mask_or #(.W(STB_W), .SKIP(BIT_RQS)) u_rqs (
    .vec (stb_base),
    .mask(sren_q),
    .hit (rqs)
  );

  always_comb begin
    status_byte          = stb_base;
    status_byte[BIT_RQS] = rqs;
  end

  assign srq = rqs;

  sbagg_mask_or #(.W(STB_W), .SKIP(-1)) u_ist (
    .vec (status_byte),
    .mask(ppen_q),
    .hit (ist)
  );

  always_comb begin
    unique case (bus_addr)
      ADDR_EVT:  bus_rdata = evt_q;
      ADDR_EVEN: bus_rdata = even_q;
      ADDR_SREN: bus_rdata = DATA_W'(sren_q);
      default:   bus_rdata = DATA_W'(ppen_q);
    endcase
  end

  AST_STB_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_s_n)
    status_byte[2:0] == 3'b000); // R2
  AST_SRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_s_n)
    srq |-> ((status_byte & sren_q & ~SREN_STUCK) != '0)); // R6
  AST_SREN_BIT6_IDLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((status_byte & sren_q & ~SREN_STUCK) == '0) |-> !srq); // R7
  AST_IST_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_s_n)
    ist |-> ((status_byte & ppen_q) != '0)); // R8
  AST_EVT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_wr && bus_addr == ADDR_EVT && !bus_rd && evt_in == '0) |=> $stable(evt_q)); // R9
endmodule

// File: tb/tb_status_byte_agg.sv
module tb_status_byte_agg;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr, bus_rd;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, evt_in, status_byte;
  logic       oper_sum, ques_sum, obuf_nonempty, srq, ist;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  status_byte_agg dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_in(evt_in), .oper_sum(oper_sum), .ques_sum(ques_sum),
    .obuf_nonempty(obuf_nonempty), .status_byte(status_byte),
    .srq(srq), .ist(ist)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic pulse_evt(input logic [7:0] e);
    @(negedge clk);
    evt_in = e;
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic clear_evt();
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 2'd0;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin
      rd_peek(a[1:0], v);
      check("R1", $sformatf("reg %0d after reset", a), v, 8'h00);
    end
    check("R1", "status byte", status_byte, 8'h00);
    check("R1", "srq/ist", {6'b0, srq, ist}, 8'h00);
  endtask

  task automatic t_stb_map();
    @(negedge clk); ques_sum = 1'b1; #1 check("R2", "ques only", status_byte, 8'h08);
    @(negedge clk); ques_sum = 1'b0; obuf_nonempty = 1'b1; #1 check("R2", "mav only", status_byte, 8'h10);
    @(negedge clk); obuf_nonempty = 1'b0; oper_sum = 1'b1; #1 check("R2", "oper only", status_byte, 8'h80);
    @(negedge clk); ques_sum = 1'b1; obuf_nonempty = 1'b1; #1 check("R2", "all three", status_byte, 8'h98);
    @(negedge clk); ques_sum = 1'b0; obuf_nonempty = 1'b0; oper_sum = 1'b0; #1 check("R2", "none", status_byte, 8'h00);
  endtask

  task automatic t_event_latch();
    logic [7:0] v;
    pulse_evt(8'h05);
    repeat (3) @(negedge clk);
    rd_peek(2'd0, v); check("R3", "latched event held", v, 8'h05);
    pulse_evt(8'h20);
    rd_peek(2'd0, v); check("R3", "events accumulate", v, 8'h25);
  endtask

  task automatic t_clear_on_read();
    logic [7:0] v;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 2'd0; evt_in = 8'h40;
    #1 v = bus_rdata; check("R4", "read returns content", v, 8'h25);
    @(negedge clk);
    bus_rd = 1'b0; evt_in = '0;
    #1 check("R4", "cleared except concurrent event", bus_rdata, 8'h40);
    clear_evt();
    rd_peek(2'd0, v); check("R4", "fully cleared", v, 8'h00);
  endtask

  task automatic t_esb();
    wr(2'd1, 8'h02);
    pulse_evt(8'h01);
    #1 check("R5", "unenabled event no esb", status_byte, 8'h00);
    pulse_evt(8'h02);
    #1 check("R5", "enabled event sets esb", status_byte, 8'h20);
    clear_evt();
    #1 check("R5", "esb drops after clear", status_byte, 8'h00);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_srq();
    wr(2'd2, 8'h10);
    @(negedge clk); obuf_nonempty = 1'b1;
    #1 check("R6", "mav enabled -> status", status_byte, 8'h50);
    check("R6", "srq high", {7'b0, srq}, 8'h01);
    @(negedge clk); obuf_nonempty = 1'b0; oper_sum = 1'b1;
    #1 check("R6", "unenabled oper no srq", {7'b0, srq}, 8'h00);
    check("R6", "status no rqs", status_byte, 8'h80);
    @(negedge clk); oper_sum = 1'b0;
    #1 check("R6", "srq stays low", {7'b0, srq}, 8'h00);
  endtask

  task automatic t_sren_bit6();
    logic [7:0] v;
    wr(2'd2, 8'hFF);
    rd_peek(2'd2, v); check("R7", "bit 6 reads 0", v, 8'hBF);
    wr(2'd2, 8'h40);
    @(negedge clk); oper_sum = 1'b1; ques_sum = 1'b1;
    #1 check("R7", "bit6-only mask no srq", {7'b0, srq}, 8'h00);
    @(negedge clk); oper_sum = 1'b0; ques_sum = 1'b0;
  endtask

  task automatic t_ist();
    wr(2'd2, 8'h80);
    wr(2'd3, 8'h40);
    @(negedge clk); oper_sum = 1'b1;
    #1 check("R8", "ist via rqs bit", {7'b0, ist}, 8'h01);
    wr(2'd2, 8'h00);
    #1 check("R8", "ist low when rqs low", {7'b0, ist}, 8'h00);
    @(negedge clk); oper_sum = 1'b0;
    wr(2'd3, 8'h08);
    @(negedge clk); ques_sum = 1'b1;
    #1 check("R8", "ist via ques", {7'b0, ist}, 8'h01);
    check("R8", "srq independent", {7'b0, srq}, 8'h00);
    @(negedge clk); ques_sum = 1'b0;
    #1 check("R8", "ist drops", {7'b0, ist}, 8'h00);
  endtask

  task automatic t_regmap();
    logic [7:0] v;
    wr(2'd1, 8'hA5); wr(2'd2, 8'h3C); wr(2'd3, 8'h5A);
    rd_peek(2'd1, v); check("R9", "event enable readback", v, 8'hA5);
    rd_peek(2'd2, v); check("R9", "srq enable readback", v, 8'h3C);
    rd_peek(2'd3, v); check("R9", "pp enable readback", v, 8'h5A);
    wr(2'd0, 8'hFF);
    rd_peek(2'd0, v); check("R9", "event write ignored", v, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    evt_in = '0; oper_sum = 1'b0; ques_sum = 1'b0; obuf_nonempty = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_stb_map();
    t_event_latch();
    t_clear_on_read();
    t_esb();
    t_srq();
    t_sren_bit6();
    t_ist();
    t_regmap();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule